// File: doc/BRIEF.md
# Genlocked Frame Buffer Address Selector

This block supplies the three frame start addresses that a recursive video filter needs in each frame period: the frame to read as current input, the frame to read as the previous (already filtered) picture, and the frame to write the result into. The addresses come from five programmable base-address values, one per slot of a circular frame store. An external genlock master picks the active slot with a 5-bit gray-coded pointer. The block brings that pointer into its own clock domain and decodes it to a slot number.

The filtered result overwrites the current input frame, so the output address always equals the current address. At each accepted vertical sync, the address that was written during the frame just ended becomes the previous-frame address for the new frame. At the same edge the block takes working copies of the line stride and the frame dimensions and raises a sticky completion flag. Software can read that flag and clear it with a single write.

Top module: `fb_addr_sel`

## Requirements
- R1: Slot selection uses these pointer codes: 5'b00000 selects slot 0, 5'b00001 slot 1, 5'b00011 slot 2, 5'b00010 slot 3 and 5'b00110 slot 4. At an accepted update, the current address becomes the base address of the selected slot. Slot k is bits k*32+31:k*32 of `base_i`.
- R2: A pointer code outside that set leaves the previous slot selection unchanged.
- R3: The output address equals the current address at all times.
- R4: At every accepted update after the first, the previous address takes the current address held just before that update.
- R5: After reset, all address, stride and size outputs are zero and the completion flag is low. At the first accepted update, the previous address takes the same value as the new current address.
- R6: An update is accepted only on a cycle where `vsync_i` rises while `upd_en_i` is high. Otherwise the addresses, stride and size outputs hold their values, including while `vsync_i` stays high.
- R7: At an accepted update, the height output takes bits 27:16 of `size_i` and the width output takes bits 11:0.
- R8: At an accepted update, the stride output takes `stride_i`. If `stride_i` is zero, it takes twice the latched width instead.
- R9: The completion flag goes high on the cycle after an accepted update and stays high. A `flag_clr_i` pulse clears it. If a clear and an update coincide, the flag ends up set.
- R10: A pointer change reaches the slot selection three clock cycles later, through two synchronizer stages and one selection register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync_i | input | 1 | Vertical sync, in the clk domain; the rising edge marks a frame boundary |
| upd_en_i | input | 1 | Allows an update at the next vsync edge |
| ptr_gray_i | input | 5 | Gray-coded slot pointer from the genlock master (asynchronous) |
| base_i | input | 160 | Five slot base addresses, 32 bits each |
| stride_i | input | 32 | Line stride setting; zero selects the default |
| size_i | input | 32 | Frame size setting: height in 27:16, width in 11:0 |
| flag_clr_i | input | 1 | Single-cycle clear of the completion flag |
| cur_addr_o | output | 32 | Current frame start address |
| prev_addr_o | output | 32 | Previous frame start address |
| out_addr_o | output | 32 | Output frame start address |
| stride_o | output | 32 | Working stride |
| height_o | output | 12 | Working frame height |
| width_o | output | 12 | Working frame width |
| upd_done_o | output | 1 | Sticky update-completion flag |

## Verification
The properties assume that `vsync_i` is already synchronous to `clk` and that `flag_clr_i` is driven in the same domain. They also assume that the pointer settles well before the vsync edge it is meant for. The bench drives every input on the falling clock edge. It changes the pointer only during gaps of several cycles with no vsync, so the synchronizer has settled before the next frame boundary. The bench does not model pointer changes that land within the three-cycle synchronizer window before a vsync edge; the assertions then still hold but the selected slot is not predicted.

// File: rtl/fba_pkg.sv
package fba_pkg;
  // Binary to gray conversion used to build the slot code set.
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/fba_ptr_track.sv
module fba_ptr_track #(
  parameter int PTR_W = 5,
  parameter int NSLOT = 5,
  parameter int IDX_W = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] ptr_gray_i,
  output logic [IDX_W-1:0] sel_o
);
  import fba_pkg::*;

  logic [PTR_W-1:0] meta_q, sync_q;
  logic [NSLOT-1:0] hit;
  logic [IDX_W-1:0] hit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= ptr_gray_i;
      sync_q <= meta_q;
    end
  end

  genvar k;
  generate
    for (k = 0; k < NSLOT; k++) begin : g_code
      localparam logic [31:0] CODE = bin2gray(32'(k));
      assign hit[k] = (sync_q == CODE[PTR_W-1:0]);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NSLOT; i++)
      if (hit[i]) hit_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst)        sel_o <= '0;
    else if (|hit)  sel_o <= hit_idx;
  end
endmodule

// File: rtl/fba_vs_edge.sv
module fba_vs_edge (
  input  logic clk,
  input  logic rst,
  input  logic vsync_i,
  input  logic upd_en_i,
  output logic take_o
);
  logic vs_d;

  always_ff @(posedge clk) begin
    if (rst) vs_d <= 1'b0;
    else     vs_d <= vsync_i;
  end

  assign take_o = vsync_i & ~vs_d & upd_en_i;
endmodule

// File: rtl/fba_latch.sv
module fba_latch #(
  parameter int AW     = 32,
  parameter int NSLOT  = 5,
  parameter int IDX_W  = $clog2(NSLOT),
  parameter int DIM_W  = 12,
  parameter int SIZE_W = 32,
  parameter int H_LSB  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [IDX_W-1:0]  sel_i,
  input  logic [NSLOT*AW-1:0] base_i,
  input  logic [AW-1:0]     stride_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              flag_clr_i,
  output logic [AW-1:0]     cur_o,
  output logic [AW-1:0]     prev_o,
  output logic [AW-1:0]     stride_o,
  output logic [DIM_W-1:0]  height_o,
  output logic [DIM_W-1:0]  width_o,
  output logic              done_o
);
  logic [AW-1:0]    base_sel;
  logic [DIM_W-1:0] w_new;
  logic             first_q;

  always_comb begin
    base_sel = '0;
    for (int i = 0; i < NSLOT; i++)
      if (sel_i == IDX_W'(i)) base_sel = base_i[i*AW +: AW];
  end

  assign w_new = size_i[DIM_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_o    <= '0;
      prev_o   <= '0;
      stride_o <= '0;
      height_o <= '0;
      width_o  <= '0;
      first_q  <= 1'b1;
    end else if (take_i) begin
      cur_o    <= base_sel;
      prev_o   <= first_q ? base_sel : cur_o;
      first_q  <= 1'b0;
      height_o <= size_i[H_LSB +: DIM_W];
      width_o  <= w_new;
      stride_o <= (stride_i == '0) ? {{(AW-DIM_W-1){1'b0}}, w_new, 1'b0} : stride_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             done_o <= 1'b0;
    else if (take_i)     done_o <= 1'b1;
    else if (flag_clr_i) done_o <= 1'b0;
  end
endmodule

// File: rtl/fb_addr_sel.sv
module fb_addr_sel #(
  parameter int AW     = 32,
  parameter int NSLOT  = 5,
  parameter int PTR_W  = 5,
  parameter int DIM_W  = 12,
  parameter int SIZE_W = 32,
  parameter int H_LSB  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vsync_i,
  input  logic                upd_en_i,
  input  logic [PTR_W-1:0]    ptr_gray_i,
  input  logic [NSLOT*AW-1:0] base_i,
  input  logic [AW-1:0]       stride_i,
  input  logic [SIZE_W-1:0]   size_i,
  input  logic                flag_clr_i,
  output logic [AW-1:0]       cur_addr_o,
  output logic [AW-1:0]       prev_addr_o,
  output logic [AW-1:0]       out_addr_o,
  output logic [AW-1:0]       stride_o,
  output logic [DIM_W-1:0]    height_o,
  output logic [DIM_W-1:0]    width_o,
  output logic                upd_done_o
);
  localparam int IDX_W = $clog2(NSLOT);

  logic [IDX_W-1:0] sel;
  logic             take;

  fba_ptr_track #(.PTR_W(PTR_W), .NSLOT(NSLOT), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst(rst), .ptr_gray_i(ptr_gray_i), .sel_o(sel)
  );

  fba_vs_edge u_edge (
    .clk(clk), .rst(rst), .vsync_i(vsync_i), .upd_en_i(upd_en_i), .take_o(take)
  );

  fba_latch #(.AW(AW), .NSLOT(NSLOT), .IDX_W(IDX_W), .DIM_W(DIM_W),
              .SIZE_W(SIZE_W), .H_LSB(H_LSB)) u_latch (
    .clk(clk), .rst(rst), .take_i(take), .sel_i(sel), .base_i(base_i),
    .stride_i(stride_i), .size_i(size_i), .flag_clr_i(flag_clr_i),
    .cur_o(cur_addr_o), .prev_o(prev_addr_o), .stride_o(stride_o),
    .height_o(height_o), .width_o(width_o), .done_o(upd_done_o)
  );

  // The filtered frame is written back over the current input frame.
  assign out_addr_o = cur_addr_o;
endmodule

// File: rtl/fb_addr_sel_chk.sv
module fb_addr_sel_chk #(
  parameter int AW    = 32,
  parameter int DIM_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             vsync_i,
  input logic             upd_en_i,
  input logic             flag_clr_i,
  input logic [AW-1:0]    cur_addr_o,
  input logic [AW-1:0]    prev_addr_o,
  input logic [AW-1:0]    stride_o,
  input logic [DIM_W-1:0] width_o,
  input logic             upd_done_o
);
  logic vs_seen, upd_seen, ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_seen  <= 1'b0;
      upd_seen <= 1'b0;
    end else begin
      vs_seen <= vsync_i;
      if (ev) upd_seen <= 1'b1;
    end
  end

  assign ev = vsync_i && !vs_seen && upd_en_i;

  AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (ev && upd_seen) |=> prev_addr_o == $past(cur_addr_o)); // R4

  AST_FIRST_PREV: assert property (@(posedge clk) disable iff (rst)
    (ev && !upd_seen) |=> prev_addr_o == cur_addr_o); // R5

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    !ev |=> ($stable(cur_addr_o) && $stable(prev_addr_o) && $stable(stride_o))); // R6

  AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
    ev |=> upd_done_o); // R9

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_i && !ev) |=> !upd_done_o); // R9

  AST_STRIDE_NZ: assert property (@(posedge clk) disable iff (rst)
    (upd_seen && width_o != '0) |-> stride_o != '0); // R8
endmodule

bind fb_addr_sel fb_addr_sel_chk #(.AW(AW), .DIM_W(DIM_W)) u_chk (
  .clk(clk), .rst(rst), .vsync_i(vsync_i), .upd_en_i(upd_en_i),
  .flag_clr_i(flag_clr_i), .cur_addr_o(cur_addr_o), .prev_addr_o(prev_addr_o),
  .stride_o(stride_o), .width_o(width_o), .upd_done_o(upd_done_o)
);

// File: tb/fb_addr_sel_test.sv
module fb_addr_sel_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vsync = 1'b0, upd_en = 1'b0, clr = 1'b0;
  logic [4:0] ptr = 5'b0;
  logic [159:0] base;
  logic [31:0] stride = 32'd0, size = 32'd0;
  logic [31:0] cur, prev, outa, stro;
  logic [11:0] hgt, wid;
  logic done;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  fb_addr_sel uut (
    .clk(clk), .rst(rst), .vsync_i(vsync), .upd_en_i(upd_en), .ptr_gray_i(ptr),
    .base_i(base), .stride_i(stride), .size_i(size), .flag_clr_i(clr),
    .cur_addr_o(cur), .prev_addr_o(prev), .out_addr_o(outa), .stride_o(stro),
    .height_o(hgt), .width_o(wid), .upd_done_o(done)
  );

  function automatic logic [31:0] bval(int k);
    return 32'h1000_0000 + 32'(k) * 32'h0010_0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ptr(logic [4:0] g);
    @(negedge clk) ptr = g;
    repeat (5) @(negedge clk);
  endtask

  task automatic frame_edge();
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
  endtask

  task automatic t_reset();
    chk("R5 cur", cur, 0); chk("R5 prev", prev, 0); chk("R5 stride", stro, 0);
    chk("R5 width", 32'(wid), 0); chk("R5 done", 32'(done), 0);
  endtask

  task automatic t_first();
    upd_en = 1'b1; size = {4'h0, 12'd480, 4'h0, 12'd720}; stride = 32'd2048;
    set_ptr(5'b00011); frame_edge();
    chk("R1 slot2", cur, bval(2));
    chk("R5 first prev", prev, bval(2));
    chk("R3 out", outa, cur);
    chk("R7 height", 32'(hgt), 480); chk("R7 width", 32'(wid), 720);
    chk("R8 stride", stro, 2048);
    chk("R9 done set", 32'(done), 1);
    @(negedge clk) clr = 1'b1; @(negedge clk) clr = 1'b0;
    chk("R9 cleared", 32'(done), 0);
  endtask

  task automatic t_rotate();
    set_ptr(5'b00110); frame_edge();
    chk("R1 slot4", cur, bval(4)); chk("R4 prev", prev, bval(2));
    chk("R3 out", outa, bval(4));
    set_ptr(5'b00010); frame_edge();
    chk("R1 slot3", cur, bval(3)); chk("R4 prev", prev, bval(4));
    set_ptr(5'b00001); frame_edge();
    chk("R1 slot1", cur, bval(1));
    set_ptr(5'b00000); frame_edge();
    chk("R1 slot0", cur, bval(0)); chk("R4 prev", prev, bval(1));
  endtask

  task automatic t_invalid();
    set_ptr(5'b00110); set_ptr(5'b11111); frame_edge();
    chk("R2 invalid keeps slot4", cur, bval(4));
    set_ptr(5'b10101); frame_edge();
    chk("R2 invalid again", cur, bval(4)); chk("R4 prev", prev, bval(4));
  endtask

  task automatic t_gating();
    set_ptr(5'b00001); upd_en = 1'b0; size = 32'h0123_0456; stride = 32'd77;
    frame_edge();
    chk("R6 no enable cur", cur, bval(4)); chk("R6 no enable width", 32'(wid), 720);
    upd_en = 1'b1;
    @(negedge clk) vsync = 1'b1;
    chk("R6 edge taken", cur, 0 + bval(4));
    @(negedge clk);
    chk("R6 edge latched", cur, bval(1));
    set_ptr(5'b00011);
    chk("R6 high hold", cur, bval(1));
    @(negedge clk) vsync = 1'b0;
  endtask

  task automatic t_stride_default();
    stride = 32'd0; size = {4'h0, 12'd100, 4'h0, 12'd1280};
    frame_edge();
    chk("R8 default stride", stro, 2560);
    chk("R7 height2", 32'(hgt), 100);
    chk("R10 slot2 after settle", cur, bval(2));
  endtask

  task automatic t_coincide();
    @(negedge clk) begin vsync = 1'b1; clr = 1'b1; end
    @(negedge clk) begin vsync = 1'b0; clr = 1'b0; end
    chk("R9 set wins", 32'(done), 1);
  endtask

  task automatic t_sync_delay();
    @(negedge clk) ptr = 5'b00110;
    @(negedge clk); @(negedge clk);
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
    chk("R10 third cycle", cur, bval(4));
  endtask

  initial begin
    for (int k = 0; k < 5; k++) base[k*32 +: 32] = bval(k);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first();
    t_rotate();
    t_invalid();
    t_gating();
    t_stride_default();
    t_coincide();
    t_sync_delay();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #1_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule